// File: doc/BRIEF.md
# MMU Control Register File with ASI Privilege Checking

This block is the register file that a load/store unit reaches through alternate address-space accesses. A request carries an 8-bit address-space identifier (ASI), a virtual address, an access size, a read/write flag and write data. The block checks the request against the core's privilege state (supervisor, hypervisor, hypervisor support present) and then either reads or writes one of its registers or reports exactly one fault. The registers are: four translation-table base registers per MMU (data and instruction), two context configuration registers per MMU, the primary and secondary context identifiers (one copy per MMU), and eight scratchpad registers.

The block answers one cycle after each request. Writes take effect at the clock edge that accepts the request. A write to a context identifier sends a one-cycle flush pulse for that context class to the translation caches. The caches themselves are outside the block. A request that faults changes no register and returns zero read data.

ASI map used by this block: 0x31, 0x32, 0x39, 0x3A are the data-MMU table bases. 0x35, 0x36, 0x3D, 0x3E are the instruction-MMU table bases. 0x33 and 0x3B are the data-MMU context configuration registers, and 0x37 and 0x3F are the instruction-MMU ones. 0x21 holds the context identifiers. 0x20 is the supervisor scratchpad and 0x4F is the hypervisor scratchpad.

Top module: `asi_mmu_regfile`

## Requirements
- R1: The privilege check applies to ASIs below 0x80 and is skipped when hypervisor mode is active. Outside hypervisor mode, a privilege trap is raised when supervisor mode is off, or when hypervisor support is present and the ASI is 0x30 or higher. ASIs of 0x80 and above never raise the privilege trap.
- R2: With hypervisor mode active, any ASI passes the privilege check, whatever the supervisor flag says.
- R3: A write to table-base ASI a selects register index {a[3], a[1]} in its MMU, so 0x31/0x35 map to 0, 0x32/0x36 to 1, 0x39/0x3D to 2 and 0x3A/0x3E to 3. Data and instruction registers are separate. A read of the same ASI returns the stored 64-bit value.
- R4: Context configuration ASIs select register a[3] (0x33/0x37 map to 0, 0x3B/0x3F map to 1) and are read back the same way.
- R5: When hypervisor support is absent, every table-base and configuration ASI that passes the privilege check raises the illegal-instruction trap and writes nothing.
- R6: Scratchpad index is address bits [5:3]. Through the hypervisor scratchpad ASI all eight entries can be read and written.
- R7: Through the supervisor scratchpad ASI, addresses 0x20 to 0x2F raise the unassigned-access error and write nothing. Other addresses reach their entry.
- R8: The context ASI decodes address bits [4:3]: 1 selects the primary context and 2 selects the secondary context. Values 0 and 3 raise the unassigned-access error. Reads return the context zero-extended.
- R9: A context write stores wdata[12:0] into both MMUs' copies. In the response cycle it raises flush_primary or flush_secondary, according to the class written, for exactly one cycle.
- R10: An access whose address is not a multiple of 2^size raises the alignment error, and no register changes.
- R11: Exactly one fault is reported, by priority privilege > alignment > illegal > unassigned. A faulting access, and any write, returns zero read data.
- R12: An ASI outside the map above that passes the privilege check raises the unassigned-access error.
- R13: rsp_valid and all result outputs come one cycle after req_valid. After reset all registers and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_asi | input | 8 | Address-space identifier |
| req_addr | input | ADDR_W | Virtual address |
| req_size | input | 2 | log2 of access bytes (0..3) |
| req_wdata | input | DATA_W | Store data |
| mode_sup | input | 1 | Supervisor mode |
| mode_hyp | input | 1 | Hypervisor mode |
| hyp_avail | input | 1 | Hypervisor support present |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W | Load data, zero on write or fault |
| trap_priv | output | 1 | Privileged-action trap |
| trap_illegal | output | 1 | Illegal-instruction trap |
| err_unassigned | output | 1 | Unassigned-access error |
| err_align | output | 1 | Alignment error |
| flush_primary | output | 1 | Flush pulse for primary-context translations |
| flush_secondary | output | 1 | Flush pulse for secondary-context translations |
| dmmu_ctx_pri | output | CTX_W | Data MMU primary context |
| dmmu_ctx_sec | output | CTX_W | Data MMU secondary context |
| immu_ctx_pri | output | CTX_W | Instruction MMU primary context |
| immu_ctx_sec | output | CTX_W | Instruction MMU secondary context |

## Verification
The embedded properties check the following on every cycle:
- User-range ASIs never take the privilege trap.
- The illegal trap only appears when hypervisor support is absent.
- A faulting request leaves the context outputs unchanged.
- Faulting responses read zero.
- The two flush pulses never coincide, and each coincides with equal data and instruction context copies.
- Responses only follow requests.

Only the directed scenarios can show the rest:
- That each ASI lands on the intended table-base, configuration or scratchpad entry.
- The supervisor scratchpad hole.
- The fault priority order.
- That rejected stores really leave register contents intact, which the bench sees by reading them back afterwards.

// File: rtl/asi_mmu_pkg.sv
package asi_mmu_pkg;

    localparam int TSB_N  = 4;
    localparam int CFG_N  = 2;
    localparam int SCR_N  = 8;
    localparam int IDX_W  = 3;

    localparam logic [7:0] ASI_SCR_SUP = 8'h20;
    localparam logic [7:0] ASI_CTX     = 8'h21;
    localparam logic [7:0] ASI_SCR_HYP = 8'h4F;
    localparam logic [7:0] ASI_HYP_LO  = 8'h30;
    localparam logic [7:0] ASI_USER_LO = 8'h80;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_TSB_D,
        TGT_TSB_I,
        TGT_CFG_D,
        TGT_CFG_I,
        TGT_CTX,
        TGT_SCR
    } tgt_e;

    typedef enum logic [2:0] {
        FLT_NONE,
        FLT_PRIV,
        FLT_ALIGN,
        FLT_ILLEGAL,
        FLT_UNASSIGNED
    } fault_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] idx;
        fault_e           fault;
    } dec_t;

    function automatic logic priv_fault(input logic [7:0] asi,
                                        input logic sup,
                                        input logic hyp,
                                        input logic hyp_present);
        return (asi < ASI_USER_LO) && !hyp &&
               (!sup || ((asi >= ASI_HYP_LO) && hyp_present));
    endfunction

    function automatic logic misaligned(input logic [2:0] low,
                                        input logic [1:0] size);
        logic [3:0] span;
        span = (4'd1 << size) - 4'd1;
        return |(low & span[2:0]);
    endfunction

endpackage

// File: rtl/asi_mmu_decode.sv
module asi_mmu_decode
    import asi_mmu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [7:0]        asi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              sup,
    input  logic              hyp,
    input  logic              hyp_avail,
    output dec_t              dec
);

    localparam logic [ADDR_W-1:0] HOLE_LO = ADDR_W'(32);
    localparam logic [ADDR_W-1:0] HOLE_HI = ADDR_W'(48);

    tgt_e             tgt;
    logic [IDX_W-1:0] idx;
    logic             hyp_only;
    logic             unasg;

    always_comb begin
        tgt      = TGT_NONE;
        idx      = '0;
        hyp_only = 1'b0;
        unasg    = 1'b0;
        case (asi)
            8'h31, 8'h32, 8'h39, 8'h3A: begin
                tgt      = TGT_TSB_D;
                idx      = {1'b0, asi[3], asi[1]};
                hyp_only = 1'b1;
            end
            8'h35, 8'h36, 8'h3D, 8'h3E: begin
                tgt      = TGT_TSB_I;
                idx      = {1'b0, asi[3], asi[1]};
                hyp_only = 1'b1;
            end
            8'h33, 8'h3B: begin
                tgt      = TGT_CFG_D;
                idx      = {2'b00, asi[3]};
                hyp_only = 1'b1;
            end
            8'h37, 8'h3F: begin
                tgt      = TGT_CFG_I;
                idx      = {2'b00, asi[3]};
                hyp_only = 1'b1;
            end
            ASI_CTX: begin
                case (addr[4:3])
                    2'd1: begin tgt = TGT_CTX; idx = 3'd0; end
                    2'd2: begin tgt = TGT_CTX; idx = 3'd1; end
                    default: unasg = 1'b1;
                endcase
            end
            ASI_SCR_SUP: begin
                if (addr >= HOLE_LO && addr < HOLE_HI) begin
                    unasg = 1'b1;
                end else begin
                    tgt = TGT_SCR;
                    idx = addr[5:3];
                end
            end
            ASI_SCR_HYP: begin
                tgt = TGT_SCR;
                idx = addr[5:3];
            end
            default: unasg = 1'b1;
        endcase
    end

    always_comb begin
        dec.tgt = tgt;
        dec.idx = idx;
        if (priv_fault(asi, sup, hyp, hyp_avail))
            dec.fault = FLT_PRIV;
        else if (misaligned(addr[2:0], size))
            dec.fault = FLT_ALIGN;
        else if (hyp_only && !hyp_avail)
            dec.fault = FLT_ILLEGAL;
        else if (unasg)
            dec.fault = FLT_UNASSIGNED;
        else
            dec.fault = FLT_NONE;
    end

    // R1: user-range ASIs never take the privilege trap
    a_r1_user_asi_unprivileged: assert property (@(posedge clk) disable iff (rst)
        (req_valid && asi[7]) |-> (dec.fault != FLT_PRIV));

    // R2: hypervisor mode clears any privilege fault
    a_r2_hyp_mode_passes: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hyp) |-> (dec.fault != FLT_PRIV));

    // R5: illegal trap only without hypervisor support
    a_r5_illegal_needs_absent: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.fault == FLT_ILLEGAL) |-> !hyp_avail);

endmodule

// File: rtl/asi_mmu_ctl_regs.sv
module asi_mmu_ctl_regs
    import asi_mmu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CTX_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  tgt_e              tgt,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [CTX_W-1:0]  d_pri,
    output logic [CTX_W-1:0]  d_sec,
    output logic [CTX_W-1:0]  i_pri,
    output logic [CTX_W-1:0]  i_sec,
    output logic              flush_pri,
    output logic              flush_sec
);

    logic [DATA_W-1:0] tsb_d_q [TSB_N];
    logic [DATA_W-1:0] tsb_i_q [TSB_N];
    logic [DATA_W-1:0] cfg_d_q [CFG_N];
    logic [DATA_W-1:0] cfg_i_q [CFG_N];

    for (genvar g = 0; g < TSB_N; g++) begin : g_tsb
        always_ff @(posedge clk) begin
            if (rst) begin
                tsb_d_q[g] <= '0;
                tsb_i_q[g] <= '0;
            end else if (wr_en && idx == IDX_W'(g)) begin
                if (tgt == TGT_TSB_D) tsb_d_q[g] <= wdata;
                if (tgt == TGT_TSB_I) tsb_i_q[g] <= wdata;
            end
        end
    end

    for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_d_q[g] <= '0;
                cfg_i_q[g] <= '0;
            end else if (wr_en && idx == IDX_W'(g)) begin
                if (tgt == TGT_CFG_D) cfg_d_q[g] <= wdata;
                if (tgt == TGT_CFG_I) cfg_i_q[g] <= wdata;
            end
        end
    end

    logic ctx_wr_pri;
    logic ctx_wr_sec;
    assign ctx_wr_pri = wr_en && tgt == TGT_CTX && idx == 3'd0;
    assign ctx_wr_sec = wr_en && tgt == TGT_CTX && idx == 3'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            d_pri     <= '0;
            d_sec     <= '0;
            i_pri     <= '0;
            i_sec     <= '0;
            flush_pri <= 1'b0;
            flush_sec <= 1'b0;
        end else begin
            flush_pri <= ctx_wr_pri;
            flush_sec <= ctx_wr_sec;
            if (ctx_wr_pri) begin
                d_pri <= wdata[CTX_W-1:0];
                i_pri <= wdata[CTX_W-1:0];
            end
            if (ctx_wr_sec) begin
                d_sec <= wdata[CTX_W-1:0];
                i_sec <= wdata[CTX_W-1:0];
            end
        end
    end

    always_comb begin
        case (tgt)
            TGT_TSB_D: rd_data = tsb_d_q[idx[1:0]];
            TGT_TSB_I: rd_data = tsb_i_q[idx[1:0]];
            TGT_CFG_D: rd_data = cfg_d_q[idx[0]];
            TGT_CFG_I: rd_data = cfg_i_q[idx[0]];
            TGT_CTX:   rd_data = DATA_W'(idx[0] ? d_sec : d_pri);
            default:   rd_data = '0;
        endcase
    end

    // R9: one class flushed at a time
    a_r9_flush_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(flush_pri && flush_sec));

    // R9: both MMU copies agree when a flush is signalled
    a_r9_copies_agree: assert property (@(posedge clk) disable iff (rst)
        (flush_pri |-> d_pri == i_pri) and (flush_sec |-> d_sec == i_sec));

endmodule

// File: rtl/asi_scratch_bank.sv
module asi_scratch_bank
    import asi_mmu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot_q [SCR_N];

    for (genvar g = 0; g < SCR_N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (wr_en && idx == IDX_W'(g))
                slot_q[g] <= wdata;
        end
    end

    assign rd_data = slot_q[idx];

endmodule

// File: rtl/asi_mmu_regfile.sv
module asi_mmu_regfile
    import asi_mmu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    parameter int CTX_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_asi,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              mode_sup,
    input  logic              mode_hyp,
    input  logic              hyp_avail,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              trap_priv,
    output logic              trap_illegal,
    output logic              err_unassigned,
    output logic              err_align,
    output logic              flush_primary,
    output logic              flush_secondary,
    output logic [CTX_W-1:0]  dmmu_ctx_pri,
    output logic [CTX_W-1:0]  dmmu_ctx_sec,
    output logic [CTX_W-1:0]  immu_ctx_pri,
    output logic [CTX_W-1:0]  immu_ctx_sec
);

    dec_t              dec;
    logic              ok;
    logic              wr_ctl;
    logic              wr_scr;
    logic [DATA_W-1:0] ctl_rd;
    logic [DATA_W-1:0] scr_rd;
    logic [DATA_W-1:0] sel_rd;

    asi_mmu_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .asi       (req_asi),
        .addr      (req_addr),
        .size      (req_size),
        .sup       (mode_sup),
        .hyp       (mode_hyp),
        .hyp_avail (hyp_avail),
        .dec       (dec)
    );

    assign ok     = req_valid && dec.fault == FLT_NONE;
    assign wr_ctl = ok && req_write && dec.tgt != TGT_SCR;
    assign wr_scr = ok && req_write && dec.tgt == TGT_SCR;

    asi_mmu_ctl_regs #(.DATA_W(DATA_W), .CTX_W(CTX_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_ctl),
        .tgt       (dec.tgt),
        .idx       (dec.idx),
        .wdata     (req_wdata),
        .rd_data   (ctl_rd),
        .d_pri     (dmmu_ctx_pri),
        .d_sec     (dmmu_ctx_sec),
        .i_pri     (immu_ctx_pri),
        .i_sec     (immu_ctx_sec),
        .flush_pri (flush_primary),
        .flush_sec (flush_secondary)
    );

    asi_scratch_bank #(.DATA_W(DATA_W)) u_scratch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_scr),
        .idx     (dec.idx),
        .wdata   (req_wdata),
        .rd_data (scr_rd)
    );

    assign sel_rd = (dec.tgt == TGT_SCR) ? scr_rd : ctl_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_rdata      <= '0;
            trap_priv      <= 1'b0;
            trap_illegal   <= 1'b0;
            err_unassigned <= 1'b0;
            err_align      <= 1'b0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_rdata      <= (ok && !req_write) ? sel_rd : '0;
            trap_priv      <= req_valid && dec.fault == FLT_PRIV;
            trap_illegal   <= req_valid && dec.fault == FLT_ILLEGAL;
            err_unassigned <= req_valid && dec.fault == FLT_UNASSIGNED;
            err_align      <= req_valid && dec.fault == FLT_ALIGN;
        end
    end

    // R10: a faulting request leaves the context identifiers unchanged
    a_r10_fault_no_write: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.fault != FLT_NONE) |=>
            ($stable(dmmu_ctx_pri) && $stable(dmmu_ctx_sec) &&
             $stable(immu_ctx_pri) && $stable(immu_ctx_sec)));

    // R11: faulting responses carry zero data
    a_r11_fault_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (trap_priv || trap_illegal || err_unassigned || err_align) |-> rsp_rdata == '0);

    // R13: a response only follows a request
    a_r13_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

endmodule

// File: tb/asi_mmu_regfile_tb.sv
module asi_mmu_regfile_tb;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 64;
    localparam int CTX_W  = 13;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [7:0]        req_asi = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'd3;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              mode_sup = 1'b0;
    logic              mode_hyp = 1'b0;
    logic              hyp_avail = 1'b1;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              trap_priv, trap_illegal, err_unassigned, err_align;
    logic              flush_primary, flush_secondary;
    logic [CTX_W-1:0]  dmmu_ctx_pri, dmmu_ctx_sec, immu_ctx_pri, immu_ctx_sec;

    always #4 clk = ~clk;

    asi_mmu_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTX_W(CTX_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_asi(req_asi), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .mode_sup(mode_sup), .mode_hyp(mode_hyp),
        .hyp_avail(hyp_avail), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .trap_priv(trap_priv), .trap_illegal(trap_illegal),
        .err_unassigned(err_unassigned), .err_align(err_align),
        .flush_primary(flush_primary), .flush_secondary(flush_secondary),
        .dmmu_ctx_pri(dmmu_ctx_pri), .dmmu_ctx_sec(dmmu_ctx_sec),
        .immu_ctx_pri(immu_ctx_pri), .immu_ctx_sec(immu_ctx_sec)
    );

    int n_chk = 0;
    int n_bad = 0;

    // fault vector order: {priv, align, illegal, unassigned}
    localparam logic [3:0] F_OK = 4'b0000, F_PRV = 4'b1000, F_ALN = 4'b0100,
                           F_ILL = 4'b0010, F_UNA = 4'b0001;

    logic [DATA_W-1:0] r_data;
    logic [3:0]        r_flt;
    logic              r_valid, r_fp, r_fs;

    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // mode: {sup, hyp, hyp_avail}
    task automatic acc(input logic wr, input logic [7:0] asi,
                       input logic [ADDR_W-1:0] addr, input logic [1:0] sz,
                       input logic [DATA_W-1:0] wd, input logic [2:0] mode);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_asi = asi; req_addr = addr;
        req_size = sz; req_wdata = wd;
        {mode_sup, mode_hyp, hyp_avail} = mode;
        @(posedge clk);
        #1;
        r_valid = rsp_valid; r_data = rsp_rdata;
        r_flt = {trap_priv, err_align, trap_illegal, err_unassigned};
        r_fp = flush_primary; r_fs = flush_secondary;
        req_valid = 1'b0;
    endtask

    localparam logic [2:0] M_USER = 3'b001, M_SUP = 3'b101, M_HYP = 3'b011,
                           M_SUP_NOHV = 3'b100;

    task automatic t_reset;
        chk("R13 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R13 reset flags", 64'({trap_priv, err_align, trap_illegal, err_unassigned}), 64'd0);
        chk("R13 reset contexts", 64'({dmmu_ctx_pri, dmmu_ctx_sec, immu_ctx_pri, immu_ctx_sec}), 64'd0);
        acc(1'b0, 8'h31, 16'h0, 2'd3, '0, M_HYP);
        chk("R13 response valid", 64'(r_valid), 64'd1);
        chk("R13 table base zero after reset", r_data, 64'd0);
    endtask

    task automatic t_tsb;
        logic [7:0] asis [8] = '{8'h31, 8'h32, 8'h39, 8'h3A, 8'h35, 8'h36, 8'h3D, 8'h3E};
        for (int i = 0; i < 8; i++)
            acc(1'b1, asis[i], 16'h0, 2'd3, 64'hA5A5_0000_0000_0000 | 64'(asis[i]), M_HYP);
        for (int i = 0; i < 8; i++) begin
            acc(1'b0, asis[i], 16'h0, 2'd3, '0, M_HYP);
            chk("R3 table base readback", r_data, 64'hA5A5_0000_0000_0000 | 64'(asis[i]));
            chk("R3 no fault", 64'(r_flt), 64'(F_OK));
        end
        acc(1'b1, 8'h3A, 16'h0, 2'd3, 64'hDEAD, M_HYP);
        chk("R11 write returns zero", r_data, 64'd0);
        acc(1'b0, 8'h3E, 16'h0, 2'd3, '0, M_HYP);
        chk("R3 instruction base untouched by data write", r_data, 64'hA5A5_0000_0000_003E);
    endtask

    task automatic t_cfg;
        logic [7:0] asis [4] = '{8'h33, 8'h3B, 8'h37, 8'h3F};
        for (int i = 0; i < 4; i++)
            acc(1'b1, asis[i], 16'h0, 2'd3, 64'hC0F0_0000 + 64'(i), M_HYP);
        for (int i = 0; i < 4; i++) begin
            acc(1'b0, asis[i], 16'h0, 2'd3, '0, M_HYP);
            chk("R4 config readback", r_data, 64'hC0F0_0000 + 64'(i));
        end
    endtask

    task automatic t_priv;
        acc(1'b0, 8'h4F, 16'h0, 2'd3, '0, M_USER);
        chk("R1 user hyp-range ASI", 64'(r_flt), 64'(F_PRV));
        acc(1'b0, 8'h20, 16'h0, 2'd3, '0, M_USER);
        chk("R1 user low ASI", 64'(r_flt), 64'(F_PRV));
        acc(1'b0, 8'h80, 16'h0, 2'd3, '0, M_USER);
        chk("R12 user ASI unmapped", 64'(r_flt), 64'(F_UNA));
        acc(1'b0, 8'h31, 16'h0, 2'd3, '0, M_SUP);
        chk("R1 supervisor hyp-range ASI", 64'(r_flt), 64'(F_PRV));
        chk("R11 priv read zero", r_data, 64'd0);
        acc(1'b1, 8'h31, 16'h0, 2'd3, 64'h1, M_SUP);
        acc(1'b0, 8'h31, 16'h0, 2'd3, '0, M_HYP);
        chk("R1 trapped store did not write", r_data, 64'hA5A5_0000_0000_0031);
        acc(1'b0, 8'h31, 16'h0, 2'd3, '0, 3'b011);
        chk("R2 hyp without sup passes", 64'(r_flt), 64'(F_OK));
        acc(1'b0, 8'h4F, 16'h0, 2'd3, '0, M_SUP_NOHV);
        chk("R1 supervisor reaches 0x4F without hv support", 64'(r_flt), 64'(F_OK));
        acc(1'b0, 8'h55, 16'h0, 2'd3, '0, M_HYP);
        chk("R12 unmapped ASI", 64'(r_flt), 64'(F_UNA));
    endtask

    task automatic t_illegal;
        acc(1'b1, 8'h32, 16'h0, 2'd3, 64'hBAD, M_SUP_NOHV);
        chk("R5 illegal without hv support", 64'(r_flt), 64'(F_ILL));
        acc(1'b0, 8'h3B, 16'h0, 2'd3, '0, M_SUP_NOHV);
        chk("R5 illegal on config read", 64'(r_flt), 64'(F_ILL));
        acc(1'b0, 8'h32, 16'h0, 2'd3, '0, M_HYP);
        chk("R5 illegal store wrote nothing", r_data, 64'hA5A5_0000_0000_0032);
    endtask

    task automatic t_scratch;
        for (int i = 0; i < 8; i++)
            acc(1'b1, 8'h4F, 16'(i * 8), 2'd3, 64'h5C00 + 64'(i), M_HYP);
        for (int i = 0; i < 8; i++) begin
            acc(1'b0, 8'h4F, 16'(i * 8), 2'd3, '0, M_HYP);
            chk("R6 hyp scratch readback", r_data, 64'h5C00 + 64'(i));
        end
        acc(1'b0, 8'h20, 16'h18, 2'd3, '0, M_SUP);
        chk("R6 sup scratch entry 3", r_data, 64'h5C03);
        acc(1'b0, 8'h20, 16'h20, 2'd3, '0, M_SUP);
        chk("R7 sup window unassigned", 64'(r_flt), 64'(F_UNA));
        chk("R7 sup window reads zero", r_data, 64'd0);
        acc(1'b1, 8'h20, 16'h28, 2'd3, 64'hFFFF, M_SUP);
        chk("R7 sup window store unassigned", 64'(r_flt), 64'(F_UNA));
        acc(1'b0, 8'h4F, 16'h28, 2'd3, '0, M_HYP);
        chk("R7 window store wrote nothing", r_data, 64'h5C05);
        acc(1'b1, 8'h20, 16'h60, 2'd3, 64'h7777, M_SUP);
        acc(1'b0, 8'h4F, 16'h20, 2'd3, '0, M_HYP);
        chk("R7 sup address 0x60 reaches entry 4", r_data, 64'h7777);
    endtask

    task automatic t_ctx;
        acc(1'b1, 8'h21, 16'h08, 2'd3, 64'hFFFF_0000_0000_1ABC, M_SUP);
        chk("R9 primary flush", 64'({r_fp, r_fs}), 64'b10);
        chk("R9 both primary copies", 64'({dmmu_ctx_pri, immu_ctx_pri}), 64'({13'h1ABC, 13'h1ABC}));
        @(posedge clk); #1;
        chk("R9 flush lasts one cycle", 64'({flush_primary, flush_secondary}), 64'd0);
        acc(1'b1, 8'h21, 16'h10, 2'd3, 64'hFFFF_FFFF, M_SUP);
        chk("R9 secondary flush", 64'({r_fp, r_fs}), 64'b01);
        chk("R9 secondary truncated both copies", 64'({dmmu_ctx_sec, immu_ctx_sec}), 64'({13'h1FFF, 13'h1FFF}));
        acc(1'b1, 8'h21, 16'h18, 2'd3, 64'h5, M_SUP);
        chk("R8 select 3 unassigned", 64'(r_flt), 64'(F_UNA));
        chk("R8 no flush on error", 64'({r_fp, r_fs}), 64'd0);
        acc(1'b1, 8'h21, 16'h00, 2'd3, 64'h5, M_SUP);
        chk("R8 select 0 unassigned", 64'(r_flt), 64'(F_UNA));
        chk("R8 contexts unchanged", 64'({dmmu_ctx_pri, dmmu_ctx_sec}), 64'({13'h1ABC, 13'h1FFF}));
        acc(1'b0, 8'h21, 16'h08, 2'd3, '0, M_SUP);
        chk("R8 primary readback", r_data, 64'h1ABC);
        acc(1'b0, 8'h21, 16'h10, 2'd3, '0, M_SUP);
        chk("R8 secondary readback", r_data, 64'h1FFF);
    endtask

    task automatic t_align;
        acc(1'b1, 8'h4F, 16'h0C, 2'd3, 64'h1234, M_HYP);
        chk("R10 misaligned 8-byte", 64'(r_flt), 64'(F_ALN));
        acc(1'b0, 8'h4F, 16'h08, 2'd3, '0, M_HYP);
        chk("R10 misaligned store wrote nothing", r_data, 64'h5C01);
        acc(1'b0, 8'h4F, 16'h09, 2'd1, '0, M_HYP);
        chk("R10 misaligned 2-byte", 64'(r_flt), 64'(F_ALN));
        acc(1'b0, 8'h4F, 16'h0C, 2'd2, '0, M_HYP);
        chk("R10 aligned 4-byte ok", 64'(r_flt), 64'(F_OK));
        acc(1'b1, 8'h21, 16'h0B, 2'd0, 64'h3, M_SUP);
        chk("R10 byte access never misaligned", 64'(r_flt), 64'(F_OK));
        chk("R10 byte store to primary", 64'(dmmu_ctx_pri), 64'h3);
    endtask

    task automatic t_prio;
        acc(1'b0, 8'h31, 16'h03, 2'd3, '0, M_USER);
        chk("R11 priv beats align", 64'(r_flt), 64'(F_PRV));
        acc(1'b0, 8'h31, 16'h03, 2'd3, '0, M_SUP_NOHV);
        chk("R11 align beats illegal", 64'(r_flt), 64'(F_ALN));
        acc(1'b0, 8'h21, 16'h19, 2'd3, '0, M_SUP);
        chk("R11 align beats unassigned", 64'(r_flt), 64'(F_ALN));
        acc(1'b0, 8'h99, 16'h01, 2'd2, '0, M_USER);
        chk("R11 user ASI align", 64'(r_flt), 64'(F_ALN));
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_tsb();
        t_cfg();
        t_priv();
        t_illegal();
        t_scratch();
        t_ctx();
        t_align();
        t_prio();
        repeat (2) @(posedge clk);
        report();
    end

endmodule